// File: doc/BRIEF.md
# Ancillary Packet Scrubber

This block sits inline on a 10-bit video word stream, one word per clock, and removes chosen ancillary packets from it. It watches the incoming words for the packet start marker (000h, 3FFh, 3FFh). It reads the identifier word that follows and decides from the identifier and a set of control inputs whether the whole packet is removed. A removed packet is not cut out of the stream. Every one of its words, from the first marker word to the checksum, is replaced with the blanking code 040h, so the line keeps its length. Words that belong to kept packets, and words outside any packet, leave the block unchanged.

Every word passes through a fixed delay of `LATENCY` clocks (default 6). The decision is known once the identifier word has arrived, and by then the marker words of that packet are still inside the delay line, so they can be blanked retroactively. The controls offer a master enable, a choice between wiping every packet and a selective mode, eight per-group bits for audio data and audio control packets, and one programmable identifier that picks out a single non-audio packet type. The control inputs are latched when a packet starts, so a change made in the middle of a packet never splits it.

Top module: `anc_scrub`

## Requirements
- R1: While `scrub_en` is 0 at a packet's sampling point, no word of that packet is changed.
- R2: With `scrub_en` = 1 and `pick_mode` = 0, every packet is removed: each word from the first marker word through the checksum comes out as 040h, one output word per input word.
- R3: With `scrub_en` = 1 and `pick_mode` = 1, an audio data packet is removed when its group bit in `grp_kill` is 1. The identifiers (low 8 bits of the identifier word) map as E7h to bit 4 (group 1), E6h to bit 5, E5h to bit 6 and E4h to bit 7 (group 4).
- R4: In the same mode, an audio control packet is removed when its bit is 1. The mapping is E3h to bit 0 (group 1), E2h to bit 1, E1h to bit 2 and E0h to bit 3 (group 4).
- R5: In the same mode, a packet whose identifier is outside E0h..E7h is removed exactly when its low 8 identifier bits equal `target_did`.
- R6: Every input word appears at `dout` exactly `LATENCY` clocks later, unchanged unless it belongs to a removed packet.
- R7: The low 8 bits of the data count word (the third word after the marker) give the number of user words. Exactly one checksum word follows them, and the word after the checksum is not touched. A count of 0 means the checksum follows the count word directly.
- R8: The controls are sampled in the clock cycle in which the third marker word is on `din`. Changes made after that point, while the packet runs, have no effect on that packet.
- R9: A new marker that arrives before the running packet's count is used up ends that packet. Words of the old packet that came before the new marker follow the old decision. The new packet, including its marker, follows its own decision.
- R10: A timing reference sequence 3FFh, 000h, 000h ends any running packet. Its words and the words that follow it up to the next marker are passed unchanged.
- R11: While `rst_n` is low, `dout` is 040h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | W (10) | Incoming video word |
| scrub_en | input | 1 | Master removal enable (1: removal allowed) |
| pick_mode | input | 1 | 0: remove every packet; 1: remove only selected packets |
| grp_kill | input | 8 | Per-group audio removal bits, data groups 4..1 at bits 7..4, control groups 4..1 at bits 3..0 |
| target_did | input | 8 | Identifier of one non-audio packet type to remove in selective mode |
| dout | output | W (10) | Delayed, filtered video word |

## Verification
A parser stuck in the wrong phase shows as blanking that runs past a checksum into the following gap words, or as a kept packet whose tail is blanked. Either appears at `dout` within `LATENCY` clocks of the word concerned. A wrongly held or wrongly refreshed control value flips the decision for a whole packet, so one wrong bit in the group decode or the identifier compare changes every word of that packet. A retroactive rewrite that misses a delay stage leaves one marker word of a removed packet unblanked, or blanks one word of a timing reference, exactly `LATENCY` clocks after that word went in.

// File: rtl/anc_scrub_pkg.sv
package anc_scrub_pkg;

   localparam int DID_W   = 8;
   localparam int GRP_N   = 8;
   localparam int CNT_W   = 8;

   // identifiers E0h..E7h share this upper field
   localparam logic [4:0] AUDIO_TOP = 5'b11100;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DID,
      ST_SDID,
      ST_DC,
      ST_UDW,
      ST_CS
   } scan_st_t;

   typedef struct packed {
      logic             en;
      logic             sel;
      logic [GRP_N-1:0] grp;
      logic [DID_W-1:0] tdid;
   } scrub_ctl_t;

endpackage

// File: rtl/anc_scrub_decide.sv
module anc_scrub_decide
   import anc_scrub_pkg::*;
(
   input  logic [DID_W-1:0] did,
   input  scrub_ctl_t       ctl,
   output logic             kill
);

   logic       is_audio;
   logic [2:0] grp_idx;
   logic       picked;

   // data: did[2]=1, control: did[2]=0; lower two bits count groups downward
   assign is_audio = (did[7:3] == AUDIO_TOP);
   assign grp_idx  = {did[2], ~did[1:0]};
   assign picked   = is_audio ? ctl.grp[grp_idx] : (did == ctl.tdid);
   assign kill     = ctl.en & (~ctl.sel | picked);

endmodule

// File: rtl/anc_scrub_parse.sv
module anc_scrub_parse
   import anc_scrub_pkg::*;
#(
   parameter int          W     = 10,
   parameter logic [W-1:0] BLANK = W'(10'h040)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  scrub_ctl_t   ctl_in,
   output scan_st_t     st,
   output scrub_ctl_t   ctl_q,
   output logic         cur_flag,
   output logic [2:0]   back_mask,
   output logic         back_val,
   output logic         pre_hit,
   output logic         trs_hit
);

   localparam logic [W-1:0] ALL0 = '0;
   localparam logic [W-1:0] ALL1 = '1;

   logic [W-1:0]     h1_q, h2_q;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             pkt_kill_q;
   logic             kill;
   scan_st_t         st_nxt;

   assign pre_hit = (h2_q == ALL0) && (h1_q == ALL1) && (din == ALL1);
   assign trs_hit = (h2_q == ALL1) && (h1_q == ALL0) && (din == ALL0);

   anc_scrub_decide u_dec (
      .did  (din[DID_W-1:0]),
      .ctl  (ctl_q),
      .kill (kill)
   );

   always_comb begin
      st_nxt    = st;
      cnt_nxt   = cnt_q;
      cur_flag  = 1'b0;
      back_mask = 3'b000;
      back_val  = 1'b0;
      unique case (st)
         ST_IDLE: ;
         ST_DID: begin
            cur_flag  = kill;
            back_mask = 3'b111;
            back_val  = kill;
            st_nxt    = ST_SDID;
         end
         ST_SDID: begin
            cur_flag = pkt_kill_q;
            st_nxt   = ST_DC;
         end
         ST_DC: begin
            cur_flag = pkt_kill_q;
            cnt_nxt  = din[CNT_W-1:0];
            st_nxt   = (din[CNT_W-1:0] == '0) ? ST_CS : ST_UDW;
         end
         ST_UDW: begin
            cur_flag = pkt_kill_q;
            cnt_nxt  = CNT_W'(cnt_q - 1'b1);
            if (cnt_q == CNT_W'(1)) st_nxt = ST_CS;
         end
         ST_CS: begin
            cur_flag = pkt_kill_q;
            st_nxt   = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
      if (trs_hit) begin
         st_nxt    = ST_IDLE;
         cur_flag  = 1'b0;
         back_mask = 3'b011;
         back_val  = 1'b0;
      end else if (pre_hit) begin
         st_nxt = ST_DID;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt_q      <= '0;
         pkt_kill_q <= 1'b0;
         ctl_q      <= '0;
         h1_q       <= BLANK;
         h2_q       <= BLANK;
      end else begin
         st    <= st_nxt;
         cnt_q <= cnt_nxt;
         h1_q  <= din;
         h2_q  <= h1_q;
         if (st == ST_DID) pkt_kill_q <= kill;
         if (st == ST_IDLE || pre_hit) ctl_q <= ctl_in;
      end
   end

endmodule

// File: rtl/anc_scrub_delay.sv
module anc_scrub_delay #(
   parameter int           W     = 10,
   parameter int           DEPTH = 5,
   parameter logic [W-1:0] BLANK = W'(10'h040)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         cur_flag,
   input  logic [2:0]   back_mask,
   input  logic         back_val,
   output logic [W-1:0] last_word,
   output logic         last_flag
);

   logic [W-1:0]     word_q [DEPTH];
   logic [DEPTH-1:0] flag_q;
   logic [DEPTH-1:0] flag_nxt;

   // stages 1..3 may be rewritten once a packet's decision is known
   for (genvar k = 0; k < DEPTH; k++) begin : g_flag
      if (k == 0) begin : g_head
         assign flag_nxt[k] = cur_flag;
      end else if (k <= 3) begin : g_fix
         assign flag_nxt[k] = back_mask[k-1] ? back_val : flag_q[k-1];
      end else begin : g_tail
         assign flag_nxt[k] = flag_q[k-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         for (int i = 0; i < DEPTH; i++) word_q[i] <= BLANK;
      end else begin
         flag_q    <= flag_nxt;
         word_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) word_q[i] <= word_q[i-1];
      end
   end

   assign last_word = word_q[DEPTH-1];
   assign last_flag = flag_q[DEPTH-1];

endmodule

// File: rtl/anc_scrub.sv
module anc_scrub
   import anc_scrub_pkg::*;
#(
   parameter int           W       = 10,
   parameter int           LATENCY = 6,
   parameter logic [W-1:0] BLANK   = W'(10'h040)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         scrub_en,
   input  logic         pick_mode,
   input  logic [7:0]   grp_kill,
   input  logic [7:0]   target_did,
   output logic [W-1:0] dout
);

   localparam int DEPTH = LATENCY - 1;

   if (W < 10) begin : g_bad_width
      $error("anc_scrub: W must be at least 10");
   end
   if (LATENCY < 6) begin : g_bad_latency
      $error("anc_scrub: LATENCY must be at least 6");
   end

   scrub_ctl_t   ctl_in;
   scrub_ctl_t   ctl_q;
   scan_st_t     st;
   logic         cur_flag;
   logic [2:0]   back_mask;
   logic         back_val;
   logic         pre_hit;
   logic         trs_hit;
   logic [W-1:0] last_word;
   logic         last_flag;

   assign ctl_in = '{en: scrub_en, sel: pick_mode, grp: grp_kill, tdid: target_did};

   anc_scrub_parse #(.W(W), .BLANK(BLANK)) u_parse (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .ctl_in    (ctl_in),
      .st        (st),
      .ctl_q     (ctl_q),
      .cur_flag  (cur_flag),
      .back_mask (back_mask),
      .back_val  (back_val),
      .pre_hit   (pre_hit),
      .trs_hit   (trs_hit)
   );

   anc_scrub_delay #(.W(W), .DEPTH(DEPTH), .BLANK(BLANK)) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .cur_flag  (cur_flag),
      .back_mask (back_mask),
      .back_val  (back_val),
      .last_word (last_word),
      .last_flag (last_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) dout <= BLANK;
      else        dout <= last_flag ? BLANK : last_word;
   end

endmodule

// File: rtl/anc_scrub_chk.sv
module anc_scrub_chk
   import anc_scrub_pkg::*;
#(
   parameter int           W     = 10,
   parameter logic [W-1:0] BLANK = W'(10'h040)
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dout,
   input  scan_st_t     st,
   input  scrub_ctl_t   ctl_q,
   input  logic         cur_flag,
   input  logic         pre_hit,
   input  logic         trs_hit,
   input  logic [W-1:0] last_word,
   input  logic         last_flag
);

   a_r1_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DID && !ctl_q.en) |-> !cur_flag);

   a_r2_blank_fill: assert property (@(posedge clk) disable iff (!rst_n)
      last_flag |=> (dout == BLANK));

   a_r6_pass_word: assert property (@(posedge clk) disable iff (!rst_n)
      !last_flag |=> (dout == $past(last_word)));

   a_r8_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && !pre_hit) |=> $stable(ctl_q));

   a_r9_marker_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_hit && !trs_hit) |=> (st == ST_DID));

   a_r10_trs_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      trs_hit |=> (st == ST_IDLE));

endmodule

bind anc_scrub anc_scrub_chk #(.W(W), .BLANK(BLANK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dout      (dout),
   .st        (st),
   .ctl_q     (ctl_q),
   .cur_flag  (cur_flag),
   .pre_hit   (pre_hit),
   .trs_hit   (trs_hit),
   .last_word (last_word),
   .last_flag (last_flag)
);

// File: tb/tb_anc_scrub.sv
`timescale 1ns/1ps
module tb_anc_scrub;

   localparam int LAT = 6;
   localparam logic [9:0] BLK = 10'h040;
   localparam logic [9:0] GAP = 10'h0A5;
   localparam int NV = 13;

   // {did, count, en, sel, grp, target, expect_removed}
   localparam logic [34:0] VEC [NV] = '{
      {8'hE7, 8'd2, 1'b0, 1'b0, 8'hFF, 8'hE7, 1'b0},
      {8'hE7, 8'd2, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1},
      {8'h45, 8'd3, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1},
      {8'hE7, 8'd1, 1'b1, 1'b1, 8'h10, 8'h00, 1'b1},
      {8'hE4, 8'd2, 1'b1, 1'b1, 8'h80, 8'h00, 1'b1},
      {8'hE5, 8'd2, 1'b1, 1'b1, 8'hBF, 8'h00, 1'b0},
      {8'hE6, 8'd0, 1'b1, 1'b1, 8'h20, 8'h00, 1'b1},
      {8'hE3, 8'd2, 1'b1, 1'b1, 8'h01, 8'h00, 1'b1},
      {8'hE0, 8'd2, 1'b1, 1'b1, 8'h08, 8'h00, 1'b1},
      {8'hE1, 8'd1, 1'b1, 1'b1, 8'hFB, 8'h00, 1'b0},
      {8'h61, 8'd3, 1'b1, 1'b1, 8'hFF, 8'h61, 1'b1},
      {8'h61, 8'd3, 1'b1, 1'b1, 8'hFF, 8'h62, 1'b0},
      {8'hE2, 8'd4, 1'b1, 1'b1, 8'h02, 8'h00, 1'b1}
   };
   string vtag [NV] = '{"R1", "R2", "R2", "R3", "R3", "R3", "R7", "R4", "R4",
                        "R4", "R5", "R5", "R4"};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] din = GAP;
   logic       scrub_en = 1'b0, pick_mode = 1'b0;
   logic [7:0] grp_kill = '0, target_did = '0;
   logic [9:0] dout;

   logic       nx_en = 1'b0, nx_sel = 1'b0;
   logic [7:0] nx_grp = '0, nx_tdid = '0;

   logic [9:0] exp_w   [4096];
   string      exp_tag [4096];
   int wr_idx = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   anc_scrub dut (
      .clk(clk), .rst_n(rst_n), .din(din), .scrub_en(scrub_en),
      .pick_mode(pick_mode), .grp_kill(grp_kill), .target_did(target_did),
      .dout(dout)
   );

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // check the word pushed LAT cycles ago, then drive the next word and controls
   task automatic push(input logic [9:0] w, input logic [9:0] e, input string tag);
      @(negedge clk);
      if (wr_idx >= LAT) begin
         total++;
         if (dout !== exp_w[wr_idx-LAT]) begin
            bad++;
            $display("FAIL %s word %0d: got %h expected %h",
                     exp_tag[wr_idx-LAT], wr_idx-LAT, dout, exp_w[wr_idx-LAT]);
         end
      end
      din        = w;
      scrub_en   = nx_en;
      pick_mode  = nx_sel;
      grp_kill   = nx_grp;
      target_did = nx_tdid;
      exp_w[wr_idx]   = e;
      exp_tag[wr_idx] = tag;
      wr_idx++;
   endtask

   task automatic pw(input logic [9:0] w, input bit kill, input string tag);
      push(w, kill ? BLK : w, tag);
   endtask

   task automatic gap(input int n, input string tag);
      for (int i = 0; i < n; i++) push(GAP, GAP, tag);
   endtask

   task automatic head(input logic [7:0] did, input logic [7:0] cnt,
                       input bit kill, input string tag);
      pw(10'h000, kill, tag);
      pw(10'h3FF, kill, tag);
      pw(10'h3FF, kill, tag);
      pw({2'b10, did}, kill, tag);
      pw(10'h101, kill, tag);
      pw({2'b10, cnt}, kill, tag);
   endtask

   task automatic send_pkt(input logic [7:0] did, input logic [7:0] cnt,
                           input bit kill, input string tag);
      head(did, cnt, kill, tag);
      for (int i = 0; i < int'(cnt); i++) pw(10'h180 + 10'(i), kill, tag);
      pw(10'h1C3, kill, tag);
   endtask

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      // R11: output during reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         total++;
         if (dout !== BLK) begin
            bad++;
            $display("FAIL R11 reset: got %h expected %h", dout, BLK);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;
      gap(LAT + 2, "R6");

      // table walk: R1..R5 and R7, with R6 on the gap words
      for (int v = 0; v < NV; v++) begin
         nx_en   = VEC[v][18];
         nx_sel  = VEC[v][17];
         nx_grp  = VEC[v][16:9];
         nx_tdid = VEC[v][8:1];
         gap(3, "R6");
         send_pkt(VEC[v][34:27], VEC[v][26:19], VEC[v][0], vtag[v]);
         gap(2, "R7");
      end

      // R8: enable drops after the sampling point -> still removed
      nx_en = 1'b1; nx_sel = 1'b0;
      gap(2, "R8");
      pw(10'h000, 1'b1, "R8");
      pw(10'h3FF, 1'b1, "R8");
      pw(10'h3FF, 1'b1, "R8");
      nx_en = 1'b0;
      pw(10'h245, 1'b1, "R8");
      pw(10'h101, 1'b1, "R8");
      pw(10'h201, 1'b1, "R8");
      pw(10'h180, 1'b1, "R8");
      pw(10'h1C3, 1'b1, "R8");
      gap(2, "R8");
      // R8: enable rises after the sampling point -> kept
      pw(10'h000, 1'b0, "R8");
      pw(10'h3FF, 1'b0, "R8");
      pw(10'h3FF, 1'b0, "R8");
      nx_en = 1'b1;
      pw(10'h245, 1'b0, "R8");
      pw(10'h101, 1'b0, "R8");
      pw(10'h201, 1'b0, "R8");
      pw(10'h180, 1'b0, "R8");
      pw(10'h1C3, 1'b0, "R8");
      gap(2, "R8");

      // R9: removed packet cut short by a new marker; new packet kept
      nx_en = 1'b1; nx_sel = 1'b0;
      head(8'h45, 8'd5, 1'b1, "R9");
      pw(10'h180, 1'b1, "R9");
      pw(10'h181, 1'b1, "R9");
      nx_sel = 1'b1; nx_grp = 8'h00; nx_tdid = 8'h00;
      send_pkt(8'h61, 8'd1, 1'b0, "R9");
      gap(3, "R9");

      // R10: removed packet cut by a timing reference; reference passes
      nx_en = 1'b1; nx_sel = 1'b0;
      head(8'h45, 8'd6, 1'b1, "R10");
      pw(10'h180, 1'b1, "R10");
      pw(10'h181, 1'b1, "R10");
      pw(10'h3FF, 1'b0, "R10");
      pw(10'h000, 1'b0, "R10");
      pw(10'h000, 1'b0, "R10");
      pw(10'h2D8, 1'b0, "R10");
      pw(10'h180, 1'b0, "R10");
      pw(10'h182, 1'b0, "R10");
      gap(LAT + 2, "R6");

      done = 1'b1;
      summary();
   end

endmodule